// File: doc/BRIEF.md
# Aligned DMA Burst Splitter

This block turns a single DMA transfer request into a series of bus bursts. A request carries a byte start address, a count of 32-bit beats, a set of enables for the fixed burst lengths (4, 8 and 16 beats), a mode bit and a cap on the largest burst. The block then hands out one burst at a time on a valid/ready port. Each burst has a start address and a length. The block keeps the remaining beat count and the next address in its own registers.

Alignment is measured against a 16-byte boundary. While the current address is off that boundary, the leading bursts are short. In undefined-length mode a single combined burst restores alignment. In fixed-length mode single beats do it. Once aligned, the block uses the largest enabled length that the cap allows. The two modes treat the final remainder differently.

The request settings are captured when the block accepts the request. After the last burst, a one-cycle done pulse follows.

Top module: `burst_splitter`

## Requirements
- R1: `req_ready` is high exactly while the block is idle. A request presented while bursts are still pending is ignored, and changing any request input after acceptance does not alter the bursts of the accepted request.
- R2: `req_len_en` bit 0 enables 4-beat, bit 1 enables 8-beat and bit 2 enables 16-beat fixed bursts. A fixed length whose bit is clear is never chosen as a body burst.
- R3: Undefined-length mode (`req_undef`=1): while the address is not a multiple of 16 bytes, exactly one burst is issued of min((16 - addr mod 16)/4, remaining, cap).
- R4: Undefined-length mode, aligned: let M be the largest enabled length not above the cap, or 1 if none is. While remaining is at least M a burst of M is issued; otherwise one burst carries all that remains.
- R5: Fixed-length mode (`req_undef`=0): while the address is not a multiple of 16 bytes, single-beat bursts are issued.
- R6: Fixed-length mode, aligned: the burst is the largest enabled length not above min(remaining, cap). If none fits, one burst of min(remaining, cap) is issued.
- R7: `req_max_len` caps every burst length; a cap of 0 acts as 1.
- R8: The first burst starts at the request address. Each later burst starts at the previous address plus 4 times the previous length.
- R9: Every burst length is nonzero, and the lengths of one request sum to its beat count.
- R10: While `bst_valid` is high and `bst_ready` is low, `bst_valid`, `bst_addr` and `bst_len` hold their values.
- R11: `done` pulses for one cycle in the cycle after the last burst handshake. A request with zero beats issues no burst and pulses `done` in the cycle after acceptance.
- R12: Synchronous reset, whether applied at startup or during a transfer, leaves `bst_valid` and `done` low and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | AW | Start byte address |
| req_beats | input | CW | Total beats (32-bit words) |
| req_undef | input | 1 | 1 = undefined-length mode, 0 = fixed-length mode |
| req_len_en | input | 3 | Enables for 4/8/16-beat bursts (bit 0/1/2) |
| req_max_len | input | 5 | Largest allowed burst length (0 treated as 1) |
| bst_valid | output | 1 | Burst descriptor valid |
| bst_ready | input | 1 | Consumer takes the burst |
| bst_addr | output | AW | Burst start byte address |
| bst_len | output | 5 | Burst length in beats |
| done | output | 1 | One-cycle pulse after the final burst |

## Verification
The first burst of a request appears on the burst port in the cycle after the request is accepted. Each later burst appears in the cycle after the previous handshake. `done` rises in the cycle after the final handshake, or after the acceptance of a zero-beat request, and it lasts a single cycle. The bench drives every input on the falling edge. It samples on the next falling edge, so each result is read exactly one rising edge after the stimulus that produced it. Stalled cycles are sampled on the following falling edge, where the held values must still be present.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    // Fixed burst lengths: BASE_LEN << i for i in [0, NUM_LEN)
    localparam int NUM_LEN     = 3;
    localparam int BASE_LEN    = 4;
    localparam int MAX_LEN     = BASE_LEN << (NUM_LEN - 1);
    localparam int LEN_W       = $clog2(MAX_LEN) + 1;

    // Beat size and alignment granule
    localparam int BEAT_BYTES  = 4;
    localparam int BEAT_SH     = $clog2(BEAT_BYTES);
    localparam int ALIGN_BYTES = 16;
    localparam int ALIGN_SH    = $clog2(ALIGN_BYTES);
    localparam int ALIGN_WORDS = ALIGN_BYTES / BEAT_BYTES;
    localparam int OFS_W       = ALIGN_SH - BEAT_SH;

    typedef enum logic {
        XFER_FIXED = 1'b0,
        XFER_UNDEF = 1'b1
    } xfer_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } bsplit_state_e;

    typedef struct packed {
        xfer_mode_e           mode;
        logic [NUM_LEN-1:0]   en;
        logic [LEN_W-1:0]     cap;
    } bsplit_cfg_t;

    // A cap of zero behaves as a cap of one beat
    function automatic logic [LEN_W-1:0] cap_floor(input logic [LEN_W-1:0] c);
        return (c == '0) ? LEN_W'(1) : c;
    endfunction

    function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/bsplit_len_pick.sv
// Largest enabled fixed length not above both the cap and a limit.
module bsplit_len_pick
    import bsplit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [NUM_LEN-1:0] en,
    input  logic [LEN_W-1:0]   cap,
    input  logic [CW-1:0]      limit,
    output logic               fit,
    output logic [LEN_W-1:0]   fit_len
);

    logic [NUM_LEN-1:0] ok;

    for (genvar i = 0; i < NUM_LEN; i++) begin : g_len
        localparam int L = BASE_LEN << i;
        assign ok[i] = en[i] && (CW'(L) <= limit) && (LEN_W'(L) <= cap);
    end

    // Ascending scan: the last eligible length is the largest one
    always_comb begin
        fit     = 1'b0;
        fit_len = '0;
        for (int i = 0; i < NUM_LEN; i++) begin
            if (ok[i]) begin
                fit     = 1'b1;
                fit_len = LEN_W'(BASE_LEN << i);
            end
        end
    end

endmodule

// File: rtl/bsplit_len_sel.sv
// Chooses the length of the current burst from address offset, remainder and settings.
module bsplit_len_sel
    import bsplit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [CW-1:0]     rem,
    input  bsplit_cfg_t       cfg,
    output logic [LEN_W-1:0]  len
);

    logic                aligned;
    logic [LEN_W-1:0]    head;
    logic [LEN_W-1:0]    cap_e;
    logic [LEN_W-1:0]    rem_lim;
    logic                body_fit;
    logic [LEN_W-1:0]    body_pick;
    logic [LEN_W-1:0]    body_len;
    logic                tail_fit;
    logic [LEN_W-1:0]    tail_len;

    assign aligned = (ofs == '0);
    assign head    = LEN_W'(ALIGN_WORDS) - LEN_W'(ofs);
    assign cap_e   = cap_floor(cfg.cap);
    assign rem_lim = (rem < CW'(cap_e)) ? rem[LEN_W-1:0] : cap_e;

    // Body length in undefined-length mode: only the cap limits it
    bsplit_len_pick #(.CW(CW)) u_pick_body (
        .en      (cfg.en),
        .cap     (cap_e),
        .limit   (CW'(cap_e)),
        .fit     (body_fit),
        .fit_len (body_pick)
    );

    // Fixed-length mode: must also fit inside what remains
    bsplit_len_pick #(.CW(CW)) u_pick_tail (
        .en      (cfg.en),
        .cap     (cap_e),
        .limit   (CW'(rem_lim)),
        .fit     (tail_fit),
        .fit_len (tail_len)
    );

    assign body_len = body_fit ? body_pick : LEN_W'(1);

    always_comb begin
        unique case (cfg.mode)
            XFER_UNDEF: begin
                if (!aligned) begin
                    len = min_len(head, rem_lim);
                end else if (rem >= CW'(body_len)) begin
                    len = body_len;
                end else begin
                    len = rem[LEN_W-1:0];
                end
            end
            default: begin
                if (!aligned) begin
                    len = LEN_W'(1);
                end else if (tail_fit) begin
                    len = tail_len;
                end else begin
                    len = rem_lim;
                end
            end
        endcase
    end

endmodule

// File: rtl/bsplit_ctrl.sv
// Request capture, burst handshake, address and remainder tracking.
module bsplit_ctrl
    import bsplit_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [CW-1:0]     req_beats,
    input  bsplit_cfg_t       req_cfg,
    output logic              req_ready,
    input  logic              bst_ready,
    input  logic [LEN_W-1:0]  len,
    output logic              bst_valid,
    output logic [AW-1:0]     cur_addr,
    output logic [CW-1:0]     rem,
    output bsplit_cfg_t       cfg,
    output logic              done
);

    bsplit_state_e state;
    logic          last;

    assign req_ready = (state == ST_IDLE);
    assign bst_valid = (state == ST_EMIT);
    assign last      = (rem == CW'(len));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            rem      <= '0;
            cfg      <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_beats == '0) begin
                            done <= 1'b1;
                        end else begin
                            cur_addr <= req_addr;
                            rem      <= req_beats;
                            cfg      <= req_cfg;
                            state    <= ST_EMIT;
                        end
                    end
                end
                default: begin
                    if (bst_ready) begin
                        cur_addr <= cur_addr + (AW'(len) << BEAT_SH);
                        rem      <= rem - CW'(len);
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
    import bsplit_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [AW-1:0]      req_addr,
    input  logic [CW-1:0]      req_beats,
    input  logic               req_undef,
    input  logic [NUM_LEN-1:0] req_len_en,
    input  logic [LEN_W-1:0]   req_max_len,
    output logic               bst_valid,
    input  logic               bst_ready,
    output logic [AW-1:0]      bst_addr,
    output logic [LEN_W-1:0]   bst_len,
    output logic               done
);

    bsplit_cfg_t       req_cfg;
    bsplit_cfg_t       cfg;
    logic [AW-1:0]     cur_addr;
    logic [CW-1:0]     rem;
    logic [LEN_W-1:0]  len;

    assign req_cfg = '{mode: xfer_mode_e'(req_undef), en: req_len_en, cap: req_max_len};

    bsplit_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_beats (req_beats),
        .req_cfg   (req_cfg),
        .req_ready (req_ready),
        .bst_ready (bst_ready),
        .len       (len),
        .bst_valid (bst_valid),
        .cur_addr  (cur_addr),
        .rem       (rem),
        .cfg       (cfg),
        .done      (done)
    );

    bsplit_len_sel #(.CW(CW)) u_sel (
        .ofs (cur_addr[ALIGN_SH-1:BEAT_SH]),
        .rem (rem),
        .cfg (cfg),
        .len (len)
    );

    assign bst_addr = cur_addr;
    assign bst_len  = len;

endmodule

// File: rtl/burst_splitter_chk.sv
module burst_splitter_chk
    import bsplit_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [CW-1:0]      req_beats,
    input logic [LEN_W-1:0]   req_max_len,
    input logic               bst_valid,
    input logic               bst_ready,
    input logic [AW-1:0]      bst_addr,
    input logic [LEN_W-1:0]   bst_len,
    input logic               done
);

    logic [CW-1:0]    owed;
    logic [LEN_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            owed  <= '0;
            cap_q <= LEN_W'(1);
        end else if (req_valid && req_ready) begin
            owed  <= req_beats;
            cap_q <= cap_floor(req_max_len);
        end else if (bst_valid && bst_ready) begin
            owed  <= owed - CW'(bst_len);
        end
    end

    assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
        bst_valid |-> !req_ready);

    assert_cap_R7: assert property (@(posedge clk) disable iff (rst)
        bst_valid |-> (bst_len <= cap_q));

    assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        (bst_valid && bst_ready) |=>
            (!bst_valid || bst_addr == $past(bst_addr) + (AW'($past(bst_len)) << BEAT_SH)));

    assert_no_overrun_R9: assert property (@(posedge clk) disable iff (rst)
        bst_valid |-> (bst_len != '0 && CW'(bst_len) <= owed));

    assert_sum_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (owed == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (bst_valid && !bst_ready) |=>
            (bst_valid && $stable(bst_addr) && $stable(bst_len)));

    assert_done_after_last_R11: assert property (@(posedge clk) disable iff (rst)
        (bst_valid && bst_ready && CW'(bst_len) == owed) |=> (done && !bst_valid));

    assert_done_cause_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(bst_valid && bst_ready) ||
                  $past(req_valid && req_ready && req_beats == '0)));

endmodule

bind burst_splitter burst_splitter_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_beats   (req_beats),
    .req_max_len (req_max_len),
    .bst_valid   (bst_valid),
    .bst_ready   (bst_ready),
    .bst_addr    (bst_addr),
    .bst_len     (bst_len),
    .done        (done)
);

// File: tb/tb_burst_splitter.sv
`timescale 1ns/1ps
module tb_burst_splitter;
    import bsplit_pkg::*;

    localparam int AW = 32;
    localparam int CW = 16;
    localparam int NV = 10;

    typedef struct packed {
        logic [31:0]          addr;
        logic [15:0]          beats;
        logic                 undef;
        logic [2:0]           en;
        logic [4:0]           cap;
        logic [3:0]           n;
        logic [0:7][4:0]      lens;
    } vec_t;

    // addr, beats, undef, enables(bit0=4,bit1=8,bit2=16), cap, count, lengths
    localparam vec_t VEC [NV] = '{
        '{32'h3A4, 16'd42, 1'b1, 3'b111, 5'd16, 4'd4, '{5'd3, 5'd16, 5'd16, 5'd7, 5'd0, 5'd0, 5'd0, 5'd0}},
        '{32'h3A4, 16'd42, 1'b0, 3'b111, 5'd16, 4'd7, '{5'd1, 5'd1, 5'd1, 5'd16, 5'd16, 5'd4, 5'd3, 5'd0}},
        '{32'h400, 16'd40, 1'b1, 3'b111, 5'd16, 4'd3, '{5'd16, 5'd16, 5'd8, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0}},
        '{32'h400, 16'd20, 1'b0, 3'b111, 5'd8,  4'd3, '{5'd8, 5'd8, 5'd4, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0}},
        '{32'h408, 16'd20, 1'b0, 3'b100, 5'd16, 4'd4, '{5'd1, 5'd1, 5'd16, 5'd2, 5'd0, 5'd0, 5'd0, 5'd0}},
        '{32'h40C, 16'd10, 1'b1, 3'b001, 5'd16, 4'd4, '{5'd1, 5'd4, 5'd4, 5'd1, 5'd0, 5'd0, 5'd0, 5'd0}},
        '{32'h404, 16'd2,  1'b1, 3'b111, 5'd16, 4'd1, '{5'd2, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0}},
        '{32'h400, 16'd5,  1'b0, 3'b000, 5'd16, 4'd1, '{5'd5, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0}},
        '{32'h400, 16'd3,  1'b1, 3'b111, 5'd0,  4'd3, '{5'd1, 5'd1, 5'd1, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0}},
        '{32'h100, 16'd37, 1'b1, 3'b110, 5'd12, 4'd5, '{5'd8, 5'd8, 5'd8, 5'd8, 5'd5, 5'd0, 5'd0, 5'd0}}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [AW-1:0]      req_addr = '0;
    logic [CW-1:0]      req_beats = '0;
    logic               req_undef = 1'b0;
    logic [NUM_LEN-1:0] req_len_en = '0;
    logic [LEN_W-1:0]   req_max_len = '0;
    logic               bst_valid;
    logic               bst_ready = 1'b0;
    logic [AW-1:0]      bst_addr;
    logic [LEN_W-1:0]   bst_len;
    logic               done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    burst_splitter #(.AW(AW), .CW(CW)) dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_beats   (req_beats),
        .req_undef   (req_undef),
        .req_len_en  (req_len_en),
        .req_max_len (req_max_len),
        .bst_valid   (bst_valid),
        .bst_ready   (bst_ready),
        .bst_addr    (bst_addr),
        .bst_len     (bst_len),
        .done        (done)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic run_vec(input int v);
        vec_t t;
        logic [31:0] exp_addr;
        logic [31:0] held_addr;
        logic [4:0]  held_len;
        int sum;
        t = VEC[v];
        exp_addr = t.addr;
        sum = 0;
        @(negedge clk);
        req_addr    = t.addr;
        req_beats   = t.beats;
        req_undef   = t.undef;
        req_len_en  = t.en;
        req_max_len = t.cap;
        req_valid   = 1'b1;
        chk(req_ready == 1'b1, "R1 ready while idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < int'(t.n); k++) begin
            chk(bst_valid == 1'b1, "R8 burst present", 32'(bst_valid), 32'd1);
            chk(bst_addr == exp_addr, "R8 burst address", bst_addr, exp_addr);
            chk(bst_len == t.lens[k], "R2 R3 R4 R5 R6 R7 burst length", 32'(bst_len), 32'(t.lens[k]));
            chk(done == 1'b0, "R11 no done while pending", 32'(done), 32'd0);
            if (k == 1) begin
                // new request with different settings while busy: must be ignored
                req_addr    = 32'hFFF0;
                req_beats   = 16'd1;
                req_undef   = ~t.undef;
                req_len_en  = 3'b000;
                req_max_len = 5'd1;
                req_valid   = 1'b1;
                chk(req_ready == 1'b0, "R1 not ready while busy", 32'(req_ready), 32'd0);
            end
            if (k % 2 == 1) begin
                held_addr = bst_addr;
                held_len  = bst_len;
                bst_ready = 1'b0;
                @(negedge clk);
                req_valid = 1'b0;
                chk(bst_valid && bst_addr == held_addr && bst_len == held_len,
                    "R10 held while stalled", bst_addr, held_addr);
            end
            sum += int'(bst_len);
            bst_ready = 1'b1;
            @(negedge clk);
            bst_ready = 1'b0;
            exp_addr = exp_addr + 32'(t.lens[k]) * 32'd4;
        end
        chk(done == 1'b1 && bst_valid == 1'b0, "R11 done after last burst", 32'(done), 32'd1);
        chk(sum == int'(t.beats), "R9 lengths sum to request", 32'(sum), 32'(t.beats));
        @(negedge clk);
        chk(done == 1'b0, "R11 done is one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bst_valid == 1'b0, "R12 reset burst valid low", 32'(bst_valid), 32'd0);
        chk(done == 1'b0, "R12 reset done low", 32'(done), 32'd0);
        chk(req_ready == 1'b1, "R12 reset ready high", 32'(req_ready), 32'd1);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_vec(v);
        end

        // zero-beat request
        @(negedge clk);
        req_addr  = 32'h200;
        req_beats = 16'd0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b1, "R11 zero beats done", 32'(done), 32'd1);
        chk(bst_valid == 1'b0, "R11 zero beats no burst", 32'(bst_valid), 32'd0);
        @(negedge clk);
        chk(done == 1'b0 && bst_valid == 1'b0, "R11 zero beats single pulse", 32'(done), 32'd0);

        // reset during a transfer
        req_addr    = 32'h3A4;
        req_beats   = 16'd42;
        req_undef   = 1'b1;
        req_len_en  = 3'b111;
        req_max_len = 5'd16;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bst_valid == 1'b1 && bst_len == 5'd3, "R3 head before reset", 32'(bst_len), 32'd3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(bst_valid == 1'b0, "R12 reset mid transfer valid", 32'(bst_valid), 32'd0);
        chk(req_ready == 1'b1, "R12 reset mid transfer ready", 32'(req_ready), 32'd1);
        chk(done == 1'b0, "R12 reset mid transfer done", 32'(done), 32'd0);

        // block still works after the mid-transfer reset
        run_vec(1);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule